// File: doc/BRIEF.md
# I2C Master Command Queue Front-End

This block sits between a register write/read port and an I2C master bit engine. Software writes 11-bit command words to a single data address. Each word carries a byte to transmit, a direction bit that turns the word into a read, a request to issue STOP after the byte, and a request to issue a repeated START before it. The words queue in a transmit FIFO and reach the engine through a valid/ready pair. Bytes that the engine receives are placed in a receive FIFO, and software takes them from the same data address.

The block holds the target-address register, which carries a 10-bit-addressing flag, and the two threshold registers. It also holds an enable request whose effect reaches a separate status bit only after the engine reports that it is idle. It produces TX_EMPTY, RX_FULL, TX_OVER and RX_UNDER indications for an interrupt controller. An abort from the engine empties both queues in one cycle.

Top module: `i2cq_frontend`

## Requirements
- R1: The engine receives each accepted command word in write order. The word is laid out as data in bits [7:0], read in bit 8, stop in bit 9 and restart in bit 10. Register address 0 is the data/command register.
- R2: When bit 8 of a written command is set, the data bits forwarded to the engine are zero, whatever was written in bits [7:0].
- R3: A write to the target register (address 1) drives `tgt_addr` from bits [9:0] and `tgt_ten` from bit 12. A read of that address returns the same two fields in the same positions, with all other bits zero.
- R4: The enable-status bit (address 3, bit 0) takes the value of the enable request (address 2, bit 0) only in a cycle where `eng_idle` is high. It holds its value while `eng_idle` is low.
- R5: A data write while enabled and with the TX FIFO holding TX_DEPTH entries is discarded. It pulses `tx_over` high for one cycle, and the TX level is unchanged.
- R6: A data-register read while the RX FIFO is empty returns zero and pulses `rx_under` high for one cycle.
- R7: An `eng_abort` pulse sets both FIFO levels to zero in the next cycle.
- R8: Address 4 returns the TX fill level and address 5 returns the RX fill level.
- R9: `tx_empty` is high while TX level <= TX threshold (address 6). `rx_full` is high while RX level > RX threshold (address 7). Both are registered and lag the level by one cycle.
- R10: While the enable request is 0, data writes are discarded and `tx_over` stays low.
- R11: While enable-status is 0, `eng_cmd_valid` stays low and queued commands remain in the FIFO.
- R12: Bytes presented on `eng_rx_valid` are returned by data-register reads in arrival order. The read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data, valid the cycle after `reg_rd` |
| eng_cmd_valid | output | 1 | A command is offered to the engine |
| eng_cmd_ready | input | 1 | Engine takes the offered command |
| eng_cmd | output | 11 | Command word at the head of the TX FIFO |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_idle | input | 1 | Engine has no transfer in progress |
| eng_abort | input | 1 | Transmit abort; flushes both FIFOs |
| tgt_addr | output | 10 | Target address to the engine |
| tgt_ten | output | 1 | 10-bit addressing selected |
| tx_empty | output | 1 | TX level at or below the TX threshold |
| rx_full | output | 1 | RX level above the RX threshold |
| tx_over | output | 1 | One-cycle pulse: write dropped on a full TX FIFO |
| rx_under | output | 1 | One-cycle pulse: read of an empty RX FIFO |

## Verification
The bench builds the block with TX_DEPTH and RX_DEPTH both set to 4. Four writes therefore fill the command queue, so the overflow pulse, the full-level hold and a threshold equal to the full depth can be reached in a few cycles. Three received bytes fall between the two threshold settings used for RX_FULL, and a fourth read reaches the underflow case. The small depth also keeps the drained sequence short enough that the scoreboard compares every command field, including a read whose data bits were written non-zero.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int CMD_W       = 11;
  localparam int TEN_BIT_POS = 12;

  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_TARGET = 3'd1,
    RA_ENABLE = 3'd2,
    RA_ENSTAT = 3'd3,
    RA_TXLVL  = 3'd4,
    RA_RXLVL  = 3'd5,
    RA_TXTHR  = 3'd6,
    RA_RXTHR  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       restart;
    logic       stop;
    logic       rd;
    logic [7:0] data;
  } cmd_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign level   = cnt;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level == $past(level))); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0)); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R8
endmodule

// File: rtl/i2cq_enable.sv
module i2cq_enable (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic eng_idle,
  output logic en_stat
);
  always_ff @(posedge clk) begin
    if (rst)           en_stat <= 1'b0;
    else if (eng_idle) en_stat <= en_req;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !eng_idle |=> (en_stat == $past(en_stat))); // R4
endmodule

// File: rtl/i2cq_frontend.sv
module i2cq_frontend
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        eng_cmd_valid,
  input  logic        eng_cmd_ready,
  output logic [10:0] eng_cmd,
  input  logic        eng_rx_valid,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_idle,
  input  logic        eng_abort,
  output logic [9:0]  tgt_addr,
  output logic        tgt_ten,
  output logic        tx_empty,
  output logic        rx_full,
  output logic        tx_over,
  output logic        rx_under
);
  localparam int TX_LW = $clog2(TX_DEPTH+1);
  localparam int RX_LW = $clog2(RX_DEPTH+1);

  reg_addr_e          addr;
  logic               wr_data, rd_data, tx_push, tx_pop;
  cmd_t               cmd_in, cmd_head;
  logic               tx_full, tx_mt, rx_full_f, rx_mt;
  logic [TX_LW-1:0]   tx_lvl, tx_thr;
  logic [RX_LW-1:0]   rx_lvl, rx_thr;
  logic [7:0]         rx_head;
  logic               en_req, en_stat;
  logic               unused_bits;

  assign addr        = reg_addr_e'(reg_addr);
  assign wr_data     = reg_wr && (addr == RA_DATA);
  assign rd_data     = reg_rd && (addr == RA_DATA);
  assign tx_push     = wr_data && en_req;
  assign unused_bits = ^reg_wdata;

  always_comb begin
    cmd_in.restart = reg_wdata[10];
    cmd_in.stop    = reg_wdata[9];
    cmd_in.rd      = reg_wdata[8];
    cmd_in.data    = reg_wdata[8] ? 8'h00 : reg_wdata[7:0];
  end

  i2cq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(eng_abort),
    .push(tx_push), .din(cmd_in),
    .pop(tx_pop), .dout(cmd_head),
    .full(tx_full), .empty(tx_mt), .level(tx_lvl)
  );

  i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(eng_abort),
    .push(eng_rx_valid), .din(eng_rx_data),
    .pop(rd_data), .dout(rx_head),
    .full(rx_full_f), .empty(rx_mt), .level(rx_lvl)
  );

  i2cq_enable u_en (
    .clk(clk), .rst(rst), .en_req(en_req), .eng_idle(eng_idle), .en_stat(en_stat)
  );

  assign eng_cmd_valid = !tx_mt && en_stat;
  assign eng_cmd       = cmd_head;
  assign tx_pop        = eng_cmd_valid && eng_cmd_ready;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_req   <= 1'b0;
      tgt_addr <= '0;
      tgt_ten  <= 1'b0;
      tx_thr   <= '0;
      rx_thr   <= '0;
    end else if (reg_wr) begin
      case (addr)
        RA_ENABLE: en_req <= reg_wdata[0];
        RA_TARGET: begin
          tgt_addr <= reg_wdata[9:0];
          tgt_ten  <= reg_wdata[TEN_BIT_POS];
        end
        RA_TXTHR:  tx_thr <= reg_wdata[TX_LW-1:0];
        RA_RXTHR:  rx_thr <= reg_wdata[RX_LW-1:0];
        default:   ;
      endcase
    end
  end

  // registered indications
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_over  <= 1'b0;
      rx_under <= 1'b0;
      tx_empty <= 1'b0;
      rx_full  <= 1'b0;
    end else begin
      tx_over  <= tx_push && tx_full;
      rx_under <= rd_data && rx_mt;
      tx_empty <= (tx_lvl <= tx_thr);
      rx_full  <= (rx_lvl > rx_thr);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (addr)
        RA_DATA:   reg_rdata <= {8'h00, rx_mt ? 8'h00 : rx_head};
        RA_TARGET: reg_rdata <= {3'b000, tgt_ten, 2'b00, tgt_addr};
        RA_ENABLE: reg_rdata <= {15'd0, en_req};
        RA_ENSTAT: reg_rdata <= {15'd0, en_stat};
        RA_TXLVL:  reg_rdata <= 16'(tx_lvl);
        RA_RXLVL:  reg_rdata <= 16'(rx_lvl);
        RA_TXTHR:  reg_rdata <= 16'(tx_thr);
        RA_RXTHR:  reg_rdata <= 16'(rx_thr);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  AST_OFF_NO_OVER: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !en_req) |=> !tx_over); // R10
  AST_UNDER_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_lvl == '0 && !eng_abort) |=> rx_under); // R6
  AST_OFF_QUEUE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!en_stat && !tx_push && !eng_abort) |=> (tx_lvl == $past(tx_lvl))); // R11
  AST_RX_FULL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rx_full_f && !rd_data && !eng_abort) |=> rx_full_f); // R12
endmodule

// File: tb/i2cq_frontend_tb.sv
module i2cq_frontend_tb;
  import i2cq_pkg::*;

  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        eng_cmd_valid, eng_cmd_ready = 1'b0;
  logic [10:0] eng_cmd;
  logic        eng_rx_valid = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_idle = 1'b0, eng_abort = 1'b0;
  logic [9:0]  tgt_addr;
  logic        tgt_ten, tx_empty, rx_full, tx_over, rx_under;

  int checks = 0;
  int fails  = 0;
  int popped = 0;
  logic [10:0] exp_q[$];

  always #2 clk = ~clk;

  i2cq_frontend #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(input reg_addr_e a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input reg_addr_e a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // driver: writes a command and records what the engine should see
  task automatic push_cmd(input logic [10:0] w, input bit expect_it);
    reg_write(RA_DATA, {5'b0, w});
    if (expect_it) exp_q.push_back(w[8] ? {w[10:8], 8'h00} : w);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  // monitor: compares each handshaken command with the scoreboard
  always @(negedge clk) begin
    if (!rst && eng_cmd_valid && eng_cmd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected command", {21'd0, eng_cmd}, 32'd0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(eng_cmd == e, "R1/R2 command word", {21'd0, eng_cmd}, {21'd0, e});
        popped++;
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) tick();
    rst = 1'b0;
    tick(); tick();

    // reset state
    chk(tx_empty == 1'b1, "R9 reset tx_empty", tx_empty, 1);
    chk(rx_full == 1'b0, "R9 reset rx_full", rx_full, 0);
    chk(eng_cmd_valid == 1'b0, "R11 reset valid", eng_cmd_valid, 0);
    reg_read(RA_ENSTAT, d);
    chk(d == 16'd0, "R4 reset enable status", d, 0);

    // writes while disabled are dropped
    push_cmd(11'h012, 1'b0);
    chk(tx_over == 1'b0, "R10 no tx_over when off", tx_over, 0);
    reg_read(RA_TXLVL, d);
    chk(d == 16'd0, "R10 level stays zero", d, 0);

    // enable handshake waits for idle
    reg_write(RA_ENABLE, 16'h0001);
    repeat (3) tick();
    reg_read(RA_ENSTAT, d);
    chk(d == 16'd0, "R4 status held while busy", d, 0);
    eng_idle = 1'b1;
    tick();
    reg_read(RA_ENSTAT, d);
    chk(d == 16'd1, "R4 status follows when idle", d, 1);

    // target register
    reg_write(RA_TARGET, 16'h1234);
    chk(tgt_ten == 1'b1 && tgt_addr == 10'h234, "R3 target outputs", {tgt_ten, tgt_addr}, {1'b1, 10'h234});
    reg_read(RA_TARGET, d);
    chk(d == 16'h1234, "R3 target readback", d, 16'h1234);
    reg_write(RA_TARGET, 16'hEC55);
    chk(tgt_ten == 1'b0 && tgt_addr == 10'h055, "R3 7-bit target", {tgt_ten, tgt_addr}, {1'b0, 10'h055});

    // fill the queue (engine not ready)
    push_cmd(11'h4A5, 1'b1);   // restart + write A5
    push_cmd(11'h03C, 1'b1);   // write 3C
    push_cmd(11'h1FF, 1'b1);   // read, data bits must be cleared
    push_cmd(11'h281, 1'b1);   // stop + write 81
    reg_read(RA_TXLVL, d);
    chk(d == 16'd4, "R8 tx level", d, 4);
    chk(tx_empty == 1'b0, "R9 tx_empty low above threshold", tx_empty, 0);

    // overflow
    push_cmd(11'h077, 1'b0);
    chk(tx_over == 1'b1, "R5 tx_over pulse", tx_over, 1);
    tick();
    chk(tx_over == 1'b0, "R5 tx_over one cycle", tx_over, 0);
    reg_read(RA_TXLVL, d);
    chk(d == 16'd4, "R5 level unchanged", d, 4);

    reg_write(RA_TXTHR, 16'd4);
    tick();
    chk(tx_empty == 1'b1, "R9 tx_empty at threshold", tx_empty, 1);

    // disabled status blocks the engine
    reg_write(RA_ENABLE, 16'h0000);
    tick();
    eng_cmd_ready = 1'b1;
    repeat (3) begin
      tick();
      chk(eng_cmd_valid == 1'b0, "R11 no issue while disabled", eng_cmd_valid, 0);
    end
    reg_read(RA_TXLVL, d);
    chk(d == 16'd4, "R11 queue kept", d, 4);

    // re-enable and drain through the scoreboard
    reg_write(RA_ENABLE, 16'h0001);
    repeat (8) tick();
    eng_cmd_ready = 1'b0;
    chk(popped == 4, "R1 all commands delivered", popped, 4);
    chk(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);
    reg_read(RA_TXLVL, d);
    chk(d == 16'd0, "R8 tx level after drain", d, 0);

    // receive path
    rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33);
    reg_read(RA_RXLVL, d);
    chk(d == 16'd3, "R8 rx level", d, 3);
    chk(rx_full == 1'b1, "R9 rx_full above threshold", rx_full, 1);
    reg_write(RA_RXTHR, 16'd3);
    tick();
    chk(rx_full == 1'b0, "R9 rx_full at threshold", rx_full, 0);
    reg_read(RA_DATA, d);
    chk(d == 16'h0011, "R12 first byte", d, 16'h0011);
    reg_read(RA_DATA, d);
    chk(d == 16'h0022, "R12 second byte", d, 16'h0022);
    reg_read(RA_DATA, d);
    chk(d == 16'h0033, "R12 third byte", d, 16'h0033);
    reg_read(RA_DATA, d);
    chk(d == 16'h0000, "R6 empty read data", d, 0);
    chk(rx_under == 1'b1, "R6 rx_under pulse", rx_under, 1);
    tick();
    chk(rx_under == 1'b0, "R6 rx_under one cycle", rx_under, 0);

    // abort flush
    push_cmd(11'h0AA, 1'b0);
    push_cmd(11'h0BB, 1'b0);
    rx_byte(8'h44); rx_byte(8'h55);
    reg_read(RA_TXLVL, d);
    chk(d == 16'd2, "R7 tx level before abort", d, 2);
    @(negedge clk); eng_abort = 1'b1;
    @(negedge clk); eng_abort = 1'b0;
    reg_read(RA_TXLVL, d);
    chk(d == 16'd0, "R7 tx flushed", d, 0);
    reg_read(RA_RXLVL, d);
    chk(d == 16'd0, "R7 rx flushed", d, 0);

    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule